// File: doc/BRIEF.md
# Bit Scan and Zero Count Unit

This execution unit finds bit positions in one operand of 16, 32 or 64 bits. It has four operations. A forward scan gives the index of the lowest set bit. A reverse scan gives the index of the highest set bit. A trailing-zero count and a leading-zero count give the number of clear bits below or above the first set bit. Bits above the chosen operand size take no part in any operation.

The caller presents the operand with the old destination value, the size select, the direction, a count request and two feature enables, then raises `in_valid`. A count runs only when it is requested and the enable for its direction is set. Otherwise the unit runs the scan in the same direction. One cycle later the unit registers the result, the carry flag and the zero flag, and marks each flag as defined or undefined.

Top module: `bitscan_unit`

## Requirements
- R1: `in_size` picks the operand width: 2'b00 selects 16 bits, 2'b01 selects 32 bits, and 2'b10 or 2'b11 selects 64 bits. Every operand bit at or above the selected width is treated as zero in all operations.
- R2: A forward scan of a nonzero operand returns the index of its least significant set bit, zero-extended to 64 bits.
- R3: A reverse scan of a nonzero operand returns the index of its most significant set bit, zero-extended to 64 bits.
- R4: A scan of a zero (masked) operand returns `in_prior` unchanged in all 64 bits.
- R5: After a scan, `out_zf` is 1 exactly when the masked operand is zero, and `out_zf_def` is 1. `out_cf_def` is 0 and `out_cf` is driven 0.
- R6: The leading-zero count returns the number of clear bits above the highest set bit, counted within the selected width. A zero operand returns the width (16, 32 or 64).
- R7: The trailing-zero count returns the number of clear bits below the lowest set bit. A zero operand returns the width (16, 32 or 64).
- R8: After a count, `out_cf` is 1 exactly when the masked operand is zero, `out_zf` is 1 exactly when the result is zero, and both defined bits are 1.
- R9: A count is performed only when `in_count` is 1 and the enable for the direction is 1 (`lzc_en` when `in_reverse`=1, `tzc_en` when `in_reverse`=0). Otherwise the scan for that direction is performed.
- R10: The outputs for an input accepted with `in_valid` at a rising edge appear after that edge. `out_valid` is high for exactly one cycle per accepted input. Result and flags hold their values while `in_valid` is low.
- R11: While `rst` is high, `out_valid`, `out_result` and all four flag bits are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_operand | input | 64 | Source operand |
| in_prior | input | 64 | Previous destination value |
| in_size | input | 2 | Operand width select |
| in_reverse | input | 1 | 1: reverse scan / leading count, 0: forward / trailing |
| in_count | input | 1 | Count operation requested |
| lzc_en | input | 1 | Leading-zero count feature enable |
| tzc_en | input | 1 | Trailing-zero count feature enable |
| out_valid | output | 1 | Result qualifier |
| out_result | output | 64 | Result |
| out_cf | output | 1 | Carry flag |
| out_cf_def | output | 1 | Carry flag defined |
| out_zf | output | 1 | Zero flag |
| out_zf_def | output | 1 | Zero flag defined |

## Verification
The bench drives zero operands at every width in every mode. A design that counted across the full 64-bit path would return 64 instead of 16 or 32, and a scan that wrote its own result would lose the prior value. A one-hot operand at every bit position under each width exposes off-by-one errors in the reverse-scan index and wrong masking near the width boundary. Random values with set bits above the width, and every mix of request and enable bits, show whether count mode leaks through a disabled feature or whether the flags follow the result where they should follow the input.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int OPW  = 64;
  localparam int CNTW = $clog2(OPW) + 1;

  typedef enum logic [1:0] {
    SZ_16  = 2'b00,
    SZ_32  = 2'b01,
    SZ_64  = 2'b10,
    SZ_64B = 2'b11
  } size_sel_e;

  function automatic logic [CNTW-1:0] width_of(input logic [1:0] sel);
    case (sel)
      SZ_16:   width_of = CNTW'(16);
      SZ_32:   width_of = CNTW'(32);
      default: width_of = CNTW'(OPW);
    endcase
  endfunction
endpackage

// File: rtl/bsz_size_mask.sv
module bsz_size_mask #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [CW-1:0] width,
  output logic [W-1:0]  mask
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask[i] = (CW'(i) < width);
  end
endmodule

// File: rtl/bsz_lead_cnt.sv
module bsz_lead_cnt #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  x,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (x[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bsz_trail_cnt.sv
module bsz_trail_cnt #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  x,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i]) cnt = CW'(i);
    end
  end
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
  import bsz_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_operand,
  input  logic [OPW-1:0] in_prior,
  input  logic [1:0]     in_size,
  input  logic           in_reverse,
  input  logic           in_count,
  input  logic           lzc_en,
  input  logic           tzc_en,
  output logic           out_valid,
  output logic [OPW-1:0] out_result,
  output logic           out_cf,
  output logic           out_cf_def,
  output logic           out_zf,
  output logic           out_zf_def
);
  logic [CNTW-1:0] width;
  logic [OPW-1:0]  mask, masked, padded;
  logic [CNTW-1:0] lz_full, tz_pad, tz_raw;
  logic            op_zero, use_count;
  logic [OPW-1:0]  nxt_result;
  logic [CNTW-1:0] cnt_val;

  assign width   = width_of(in_size);

  bsz_size_mask #(.W(OPW), .CW(CNTW)) u_mask (.width(width), .mask(mask));

  assign masked  = in_operand & mask;
  assign padded  = masked | ~mask;
  assign op_zero = (masked == '0);

  bsz_lead_cnt  #(.W(OPW), .CW(CNTW)) u_lead  (.x(masked), .cnt(lz_full));
  bsz_trail_cnt #(.W(OPW), .CW(CNTW)) u_trpad (.x(padded), .cnt(tz_pad));
  bsz_trail_cnt #(.W(OPW), .CW(CNTW)) u_trraw (.x(masked), .cnt(tz_raw));

  assign use_count = in_count && (in_reverse ? lzc_en : tzc_en);

  always_comb begin
    cnt_val = in_reverse ? (lz_full + width - CNTW'(OPW)) : tz_pad;
    if (use_count) begin
      nxt_result = OPW'(cnt_val);
    end else if (op_zero) begin
      nxt_result = in_prior;
    end else if (in_reverse) begin
      nxt_result = OPW'(CNTW'(OPW - 1) - lz_full);
    end else begin
      nxt_result = OPW'(tz_raw);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cf     <= 1'b0;
      out_cf_def <= 1'b0;
      out_zf     <= 1'b0;
      out_zf_def <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nxt_result;
        out_zf_def <= 1'b1;
        out_cf_def <= use_count;
        out_cf     <= use_count && op_zero;
        out_zf     <= use_count ? (cnt_val == '0) : op_zero;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_zf) && $stable(out_cf));
  // R4
  scan_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_count && (masked == '0)) |=> (out_result == $past(in_prior)));
  // R5
  scan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_cf_def) |-> (out_zf_def && !out_cf));
  // R8
  count_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cf_def && out_zf) |-> !out_cf);
  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cf_def) |-> (out_result <= OPW'(OPW)));
endmodule

// File: tb/sim_bitscan_unit.sv
`timescale 1ns/1ps
module sim_bitscan_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_operand, in_prior;
  logic [1:0]  in_size;
  logic        in_reverse, in_count, lzc_en, tzc_en;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_cf, out_cf_def, out_zf, out_zf_def;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bitscan_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_prior(in_prior), .in_size(in_size), .in_reverse(in_reverse),
    .in_count(in_count), .lzc_en(lzc_en), .tzc_en(tzc_en),
    .out_valid(out_valid), .out_result(out_result), .out_cf(out_cf),
    .out_cf_def(out_cf_def), .out_zf(out_zf), .out_zf_def(out_zf_def));

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R10: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference computed per the requirements, within the width
  task automatic ref_calc(input logic [63:0] op, input logic [63:0] prior,
                          input logic [1:0] sz, input logic rev, input logic req,
                          input logic le, input logic te,
                          output logic [63:0] res, output logic cf, output logic cfd,
                          output logic zf, output logic zfd);
    int n, lz, tz;
    logic [63:0] m;
    logic cnt;
    n = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
    m = '0;
    for (int i = 0; i < n; i++) m[i] = op[i];
    lz = n;
    for (int i = 0; i < n; i++) if (m[i]) lz = n - 1 - i;
    tz = n;
    for (int i = n - 1; i >= 0; i--) if (m[i]) tz = i;
    cnt = req && (rev ? le : te);
    zfd = 1'b1;
    if (cnt) begin
      res = rev ? 64'(lz) : 64'(tz);
      cf  = (m == '0);
      cfd = 1'b1;
      zf  = (res == '0);
    end else begin
      cfd = 1'b0;
      cf  = 1'b0;
      zf  = (m == '0);
      if (m == '0) res = prior;
      else res = rev ? 64'(n - 1 - lz) : 64'(tz);
    end
  endtask

  task automatic run(input logic [63:0] op, input logic [63:0] prior,
                     input logic [1:0] sz, input logic rev, input logic req,
                     input logic le, input logic te);
    logic [63:0] er;
    logic ecf, ecfd, ezf, ezfd;
    string rq;
    ref_calc(op, prior, sz, rev, req, le, te, er, ecf, ecfd, ezf, ezfd);
    if (req && (rev ? le : te)) rq = rev ? "R6/R8/R9" : "R7/R8/R9";
    else if ((op & ((sz == 2'b00) ? 64'hFFFF : (sz == 2'b01) ? 64'hFFFF_FFFF : '1)) == '0) rq = "R4/R5/R1";
    else rq = rev ? "R3/R5/R1" : "R2/R5/R1";
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_prior = prior; in_size = sz;
    in_reverse = rev; in_count = req; lzc_en = le; tzc_en = te;
    @(negedge clk);
    in_valid = 1'b0;
    in_operand = ~op;
    cmp({rq, " result"}, out_result, er);
    cmp({rq, " flags"}, {60'd0, out_cf, out_cf_def, out_zf, out_zf_def},
        {60'd0, ecf, ecfd, ezf, ezfd});
    cmp("R10 valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_prior = '0; in_size = '0;
    in_reverse = 1'b0; in_count = 1'b0; lzc_en = 1'b0; tzc_en = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    cmp("R11 reset", {out_result[59:0], out_valid, out_cf, out_cf_def, out_zf}, '0);
    cmp("R11 reset zfd", 64'(out_zf_def), 64'd0);
    rst = 1'b0;

    // zero operand in every mode and width, with junk above the width
    for (int s = 0; s < 3; s++)
      for (int md = 0; md < 8; md++) begin
        run(64'd0, 64'hDEAD_BEEF_0123_4567, 2'(s), md[0], md[1], md[2], md[2]);
        if (s < 2) run(64'hFFFF_FFFF_0000_0000 << (s == 0 ? 0 : 0) | (s == 0 ? 64'hFFFF_0000 : 64'h0),
                       64'hA5A5_5A5A_0F0F_F0F0, 2'(s), md[0], md[1], md[2], md[2]);
      end

    // R9: enable of the opposite direction must not enable count
    run(64'h0000_0000_0001_0000, 64'h7, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
    run(64'h0000_0000_0001_0000, 64'h7, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
    // R1: size 2'b11 behaves as 64
    run(64'h8000_0000_0000_0000, 64'h0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
    run(64'h8000_0000_0000_0000, 64'h0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);

    // one-hot at every position, every width, all four operations
    for (int p = 0; p < 64; p++)
      for (int s = 0; s < 3; s++)
        for (int md = 0; md < 4; md++)
          run(64'd1 << p, 64'h1111_2222_3333_4444, 2'(s), md[0], md[1], 1'b1, 1'b1);

    // random, mixed density
    for (int k = 0; k < 1500; k++) begin
      logic [63:0] v;
      v = {$urandom(), $urandom()};
      if (k % 3 == 1) v = v >> ($urandom() % 64);
      if (k % 3 == 2) v = v << ($urandom() % 64);
      run(v, {$urandom(), $urandom()}, 2'($urandom()), 1'($urandom()),
          1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    // R10: outputs hold while idle
    run(64'h0000_0000_0000_0100, 64'h0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    keep = out_result;
    repeat (3) @(negedge clk);
    cmp("R10 hold", out_result, keep);
    cmp("R10 idle valid", 64'(out_valid), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule